// File: doc/BRIEF.md
# BCH8 sector bit-flip corrector

This block finishes the correction of one 512-byte sector after a BCH8 decoder has found its error positions. On a start strobe it captures the decoder's error count, its list of up to eight bit positions and its uncorrectable flag, together with the ECC bytes read from the page's spare area. Each position is expressed in codeword bit space. The parity bits sit at the low end of that space. Data bits count downward from the last byte of the sector. Positions inside the parity span are dropped. Each remaining position becomes a byte address and a bit mask. That bit is inverted through a read-modify-write on a byte-wide synchronous memory port that holds the sector.

Two cases bypass the memory entirely. If every stored spare-area ECC byte is 0xFF, the page is taken to be freshly erased and nothing is flipped. If the decoder reported an uncorrectable sector, the block raises a failure flag and flips nothing. A separate combinational path reverses the byte order of the freshly computed ECC bytes to form the syndrome that the decoder expects as input. The block reports how many bits it flipped in the sector.

Top module: `bch_bitflip_fixer`

## Requirements
- R1: A location of 103 or below falls in the 104-bit parity span (26 nibbles). It causes no memory access, and the sector contents stay unchanged.
- R2: A location L in 104..4199 targets byte address (4095 - (L - 104)) / 8 and bit (L - 104) mod 8, where bit 0 is the least significant. A location of 4200 or above is skipped like a parity location.
- R3: Each targeted bit is corrected in two cycles. In the first cycle a read is issued to the byte address. In the second cycle the returned byte is written back to the same address with only the target bit inverted. A skipped location takes one cycle. Locations are handled in list order, with location i at err_locs[13*i +: 13], so done is seen 1 + (2 per corrected, 1 per skipped) cycles after start.
- R4: An error count of 0 raises done in the cycle after start, with no memory access and a flip count of 0.
- R5: An error count above 8 is clamped to 8. Only locations 0..7 are used, and the flip count never exceeds 8.
- R6: When all 104 bits of stored_ecc are 1, the sector is treated as erased. erased is set, done follows in the next cycle, and no memory access occurs. This case takes priority over R7.
- R7: When uncorrectable is set on start and the page is not erased, fail is set, done follows in the next cycle, and no bit is flipped.
- R8: flip_count equals the number of write-backs made for the current sector. It is cleared at start.
- R9: done is a one-cycle pulse. fail, erased and flip_count hold their values until the next accepted start.
- R10: syndrome byte i (bits 8i+7..8i) equals calc_ecc byte 12-i, combinationally.
- R11: start is ignored while busy is high.
- R12: After reset, busy, done, fail, erased, flip_count, mem_rd_en and mem_wr_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin processing one sector |
| err_count | input | 4 | Number of error locations from the decoder |
| err_locs | input | 104 | Eight 13-bit codeword bit locations, location i at [13i+12:13i] |
| uncorrectable | input | 1 | Decoder could not correct the sector |
| stored_ecc | input | 104 | 13 ECC bytes read from the spare area |
| calc_ecc | input | 104 | 13 ECC bytes computed over the data |
| syndrome | output | 104 | calc_ecc in reversed byte order |
| mem_addr | output | 9 | Sector byte address |
| mem_rd_en | output | 1 | Read request; data returns on mem_rdata one cycle later |
| mem_rdata | input | 8 | Read data |
| mem_wr_en | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Sector in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Sector was uncorrectable |
| erased | output | 1 | Sector was treated as erased |
| flip_count | output | 4 | Bits flipped in the current sector |

## Verification
The three bypass cases (zero count, erased page, uncorrectable) must show done exactly one cycle after the start edge. A sector with locations must show done after one cycle plus two for every corrected location and one for every skipped location. For each stimulus the bench computes this latency independently. It counts falling edges from the start strobe until done appears and compares the count with the expected value. It samples flags, the flip count, the number of writes and the whole sector image only after done. Because the sector image is compared against a model that applies the requirement's formula, any wrong address, wrong mask or missing read-after-write ordering between two flips in the same byte shows up.

// File: rtl/bchfix_pkg.sv
package bchfix_pkg;

    typedef enum logic [1:0] {
        FX_IDLE  = 2'd0,
        FX_SCAN  = 2'd1,
        FX_PATCH = 2'd2
    } fix_state_e;

endpackage

// File: rtl/bchfix_loc_map.sv
// Maps one codeword bit location onto a sector byte address and bit mask.
module bchfix_loc_map #(
    parameter int PAR_BITS  = 104,
    parameter int DATA_BITS = 4096,
    parameter int LOC_W     = 13,
    parameter int ADDR_W    = 9
) (
    input  logic [LOC_W-1:0]  loc,
    output logic              hit,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [7:0]        bit_mask
);
    int data_pos;

    always_comb begin
        data_pos  = int'(loc) - PAR_BITS;
        hit       = (int'(loc) >= PAR_BITS) && (int'(loc) < PAR_BITS + DATA_BITS);
        byte_addr = '0;
        bit_mask  = '0;
        if (hit) begin
            byte_addr = ADDR_W'((DATA_BITS - 1 - data_pos) / 8);
            bit_mask  = 8'(1 << (data_pos % 8));
        end
    end
endmodule

// File: rtl/bchfix_erase_detect.sv
// Flags a spare-area ECC field whose bytes are all 0xFF.
module bchfix_erase_detect #(
    parameter int NBYTES = 13
) (
    input  logic [NBYTES*8-1:0] ecc,
    output logic                all_ff
);
    logic [NBYTES-1:0] byte_ff;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign byte_ff[g] = &ecc[g*8 +: 8];
    end

    assign all_ff = &byte_ff;
endmodule

// File: rtl/bchfix_syn_reverse.sv
// Reverses byte order: output byte i takes input byte NBYTES-1-i.
module bchfix_syn_reverse #(
    parameter int NBYTES = 13
) (
    input  logic [NBYTES*8-1:0] din,
    output logic [NBYTES*8-1:0] dout
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_swap
        assign dout[g*8 +: 8] = din[(NBYTES-1-g)*8 +: 8];
    end
endmodule

// File: rtl/bch_bitflip_fixer.sv
module bch_bitflip_fixer
    import bchfix_pkg::*;
#(
    parameter int SECTOR_BYTES   = 512,
    parameter int PARITY_NIBBLES = 26,
    parameter int MAX_ERRS       = 8,
    localparam int PAR_BITS  = PARITY_NIBBLES * 4,
    localparam int DATA_BITS = SECTOR_BYTES * 8,
    localparam int LOC_W     = $clog2(PAR_BITS + DATA_BITS),
    localparam int ADDR_W    = $clog2(SECTOR_BYTES),
    localparam int ECC_BYTES = PARITY_NIBBLES / 2,
    localparam int CNT_W     = $clog2(MAX_ERRS + 1),
    localparam int IDX_W     = (MAX_ERRS > 1) ? $clog2(MAX_ERRS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [CNT_W-1:0]          err_count,
    input  logic [MAX_ERRS*LOC_W-1:0] err_locs,
    input  logic                      uncorrectable,
    input  logic [ECC_BYTES*8-1:0]    stored_ecc,
    input  logic [ECC_BYTES*8-1:0]    calc_ecc,
    output logic [ECC_BYTES*8-1:0]    syndrome,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic                      mem_rd_en,
    input  logic [7:0]                mem_rdata,
    output logic                      mem_wr_en,
    output logic [7:0]                mem_wdata,
    output logic                      busy,
    output logic                      done,
    output logic                      fail,
    output logic                      erased,
    output logic [CNT_W-1:0]          flip_count
);

    typedef struct packed {
        fix_state_e                st;
        logic [IDX_W-1:0]          idx;
        logic [CNT_W-1:0]          cnt;
        logic [MAX_ERRS*LOC_W-1:0] locs;
        logic [ADDR_W-1:0]         addr;
        logic [7:0]                mask;
        logic [CNT_W-1:0]          flips;
        logic                      done;
        logic                      fail;
        logic                      erased;
    } fix_regs_t;

    fix_regs_t r_d, r_q;

    logic [LOC_W-1:0]  cur_loc;
    logic              loc_hit;
    logic [ADDR_W-1:0] loc_addr;
    logic [7:0]        loc_mask;
    logic              page_erased;
    logic              at_last;
    logic [CNT_W-1:0]  cnt_clamped;

    assign cur_loc = r_q.locs[int'(r_q.idx)*LOC_W +: LOC_W];

    bchfix_loc_map #(
        .PAR_BITS (PAR_BITS),
        .DATA_BITS(DATA_BITS),
        .LOC_W    (LOC_W),
        .ADDR_W   (ADDR_W)
    ) i_loc_map (
        .loc      (cur_loc),
        .hit      (loc_hit),
        .byte_addr(loc_addr),
        .bit_mask (loc_mask)
    );

    bchfix_erase_detect #(.NBYTES(ECC_BYTES)) i_erase (
        .ecc   (stored_ecc),
        .all_ff(page_erased)
    );

    bchfix_syn_reverse #(.NBYTES(ECC_BYTES)) i_syn (
        .din (calc_ecc),
        .dout(syndrome)
    );

    assign cnt_clamped = (err_count > CNT_W'(MAX_ERRS)) ? CNT_W'(MAX_ERRS) : err_count;
    assign at_last     = (CNT_W'(r_q.idx) + CNT_W'(1)) == r_q.cnt;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        mem_addr  = '0;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_wdata = '0;
        unique case (r_q.st)
            FX_IDLE: begin
                if (start) begin
                    r_d.flips  = '0;
                    r_d.fail   = 1'b0;
                    r_d.erased = 1'b0;
                    r_d.idx    = '0;
                    if (page_erased) begin
                        r_d.erased = 1'b1;
                        r_d.done   = 1'b1;
                    end else if (uncorrectable) begin
                        r_d.fail = 1'b1;
                        r_d.done = 1'b1;
                    end else if (cnt_clamped == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.cnt  = cnt_clamped;
                        r_d.locs = err_locs;
                        r_d.st   = FX_SCAN;
                    end
                end
            end
            FX_SCAN: begin
                if (loc_hit) begin
                    mem_rd_en = 1'b1;
                    mem_addr  = loc_addr;
                    r_d.addr  = loc_addr;
                    r_d.mask  = loc_mask;
                    r_d.st    = FX_PATCH;
                end else if (at_last) begin
                    r_d.done = 1'b1;
                    r_d.st   = FX_IDLE;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                end
            end
            FX_PATCH: begin
                mem_wr_en = 1'b1;
                mem_addr  = r_q.addr;
                mem_wdata = mem_rdata ^ r_q.mask;
                r_d.flips = r_q.flips + CNT_W'(1);
                if (at_last) begin
                    r_d.done = 1'b1;
                    r_d.st   = FX_IDLE;
                end else begin
                    r_d.idx = r_q.idx + IDX_W'(1);
                    r_d.st  = FX_SCAN;
                end
            end
            default: r_d.st = FX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != FX_IDLE);
    assign done       = r_q.done;
    assign fail       = r_q.fail;
    assign erased     = r_q.erased;
    assign flip_count = r_q.flips;

    // R3: a write-back always follows a read of the same byte
    assert_patch_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($past(mem_rd_en) && (mem_addr == $past(mem_addr))));

    // R5: never more flips than the clamp allows
    assert_flip_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flip_count <= CNT_W'(MAX_ERRS));

    // R6: an erased sector finishes with nothing flipped
    assert_erased_noflip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && erased) |-> (flip_count == '0));

    // R7: an uncorrectable sector finishes with nothing flipped
    assert_fail_noflip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (flip_count == '0));

    // R9: done lasts one cycle unless a new start arrives at once
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

endmodule

// File: tb/test_bch_bitflip_fixer.sv
module test_bch_bitflip_fixer;

    typedef struct packed {
        logic [3:0]   cnt;
        logic         uncor;
        logic         ers;
        logic [103:0] locs;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{4'd1,  1'b0, 1'b0, {{7{13'd0}}, 13'd104}},
        '{4'd3,  1'b0, 1'b0, {{5{13'd0}}, 13'd1000, 13'd50, 13'd4199}},
        '{4'd0,  1'b0, 1'b0, {8{13'd104}}},
        '{4'd2,  1'b0, 1'b0, {{6{13'd0}}, 13'd0, 13'd103}},
        '{4'd12, 1'b0, 1'b0, {13'd3000, 13'd2000, 13'd104, 13'd4300,
                              13'd300, 13'd300, 13'd201, 13'd200}},
        '{4'd2,  1'b0, 1'b1, {{7{13'd0}}, 13'd500}},
        '{4'd1,  1'b1, 1'b0, {{7{13'd0}}, 13'd500}},
        '{4'd1,  1'b1, 1'b1, {{7{13'd0}}, 13'd500}}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [3:0]   err_count = '0;
    logic [103:0] err_locs = '0;
    logic         uncorrectable = 1'b0;
    logic [103:0] stored_ecc = '0;
    logic [103:0] calc_ecc = '0;
    logic [103:0] syndrome;
    logic [8:0]   mem_addr;
    logic         mem_rd_en;
    logic [7:0]   mem_rdata = '0;
    logic         mem_wr_en;
    logic [7:0]   mem_wdata;
    logic         busy, done, fail, erased;
    logic [3:0]   flip_count;

    logic [7:0] sram   [512];
    logic [7:0] golden [512];
    int wr_count = 0;
    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    bch_bitflip_fixer i_bch_bitflip_fixer (
        .clk(clk), .rst_n(rst_n), .start(start), .err_count(err_count),
        .err_locs(err_locs), .uncorrectable(uncorrectable),
        .stored_ecc(stored_ecc), .calc_ecc(calc_ecc), .syndrome(syndrome),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .busy(busy),
        .done(done), .fail(fail), .erased(erased), .flip_count(flip_count)
    );

    always @(posedge clk) begin
        if (mem_wr_en) begin
            sram[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
        if (mem_rd_en) mem_rdata <= sram[mem_addr];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int mem_mismatches();
        int n = 0;
        for (int i = 0; i < 512; i++) if (sram[i] !== golden[i]) n++;
        return n;
    endfunction

    task automatic run_vec(input vec_t v, input string tag);
        int n, lat, cost, flips, loc, d, w0;
        n = (v.cnt > 8) ? 8 : int'(v.cnt);
        cost = 0; flips = 0;
        if (!v.ers && !v.uncor) begin
            for (int i = 0; i < n; i++) begin
                loc = int'(v.locs[13*i +: 13]);
                if (loc >= 104 && loc < 4200) begin
                    d = loc - 104;
                    golden[(4095 - d) / 8] ^= 8'(1 << (d % 8));
                    cost += 2; flips++;
                end else begin
                    cost += 1;
                end
            end
        end
        w0 = wr_count;
        err_count     = v.cnt;
        err_locs      = v.locs;
        uncorrectable = v.uncor;
        stored_ecc    = v.ers ? {104{1'b1}} : {8'hFE, {96{1'b1}}};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(lat == 1 + cost, {tag, " R3 done latency"}, lat, 1 + cost);
        check(int'(flip_count) == flips, {tag, " R8 flip_count"}, int'(flip_count), flips);
        check(wr_count - w0 == flips, {tag, " R1 write count"}, wr_count - w0, flips);
        check(mem_mismatches() == 0, {tag, " R2 sector image mismatches"}, mem_mismatches(), 0);
        check(erased == v.ers, {tag, " R6 erased flag"}, int'(erased), int'(v.ers));
        check(fail == (v.uncor && !v.ers), {tag, " R7 fail flag"}, int'(fail),
              int'(v.uncor && !v.ers));
        @(negedge clk);
        check(done == 1'b0, {tag, " R9 done pulse width"}, int'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            sram[i]   = 8'(i * 7 + 3);
            golden[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R12 reset state
        check(!busy && !done && !fail && !erased, "R12 reset flags",
              int'({busy, done, fail, erased}), 0);
        check(flip_count == 0 && !mem_rd_en && !mem_wr_en, "R12 reset count/port",
              int'({flip_count, mem_rd_en, mem_wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 syndrome byte reversal
        for (int i = 0; i < 13; i++) calc_ecc[8*i +: 8] = 8'(8'h10 + i);
        #1;
        for (int i = 0; i < 13; i++)
            check(syndrome[8*i +: 8] == 8'(8'h10 + 12 - i), "R10 syndrome byte",
                  int'(syndrome[8*i +: 8]), 16 + 12 - i);

        // Vector table: R1 R2 R3 R4 R5 R6 R7 R8 R9
        for (int k = 0; k < NVEC; k++) begin
            string tag;
            tag = $sformatf("vec%0d", k);
            run_vec(VECS[k], tag);
        end

        // R9 flags hold after done until the next start
        run_vec(VECS[5], "hold");
        repeat (3) @(negedge clk);
        check(erased == 1'b1, "R9 erased held", int'(erased), 1);

        // R11 start ignored while busy
        begin
            int d;
            d = 1000 - 104;
            golden[(4095 - d) / 8] ^= 8'(1 << (d % 8));
            err_count = 4'd1; err_locs = {{7{13'd0}}, 13'd1000};
            uncorrectable = 1'b0; stored_ecc = '0;
            start = 1'b1;
            @(negedge clk);
            check(busy == 1'b1, "R11 busy after start", int'(busy), 1);
            uncorrectable = 1'b1; err_locs = {{7{13'd0}}, 13'd2500};
            @(negedge clk);
            start = 1'b0;
            while (!done) @(negedge clk);
            check(fail == 1'b0, "R11 busy start ignored (fail)", int'(fail), 0);
            check(flip_count == 4'd1, "R11 single flip", int'(flip_count), 1);
            repeat (2) @(negedge clk);
            check(mem_mismatches() == 0, "R11 sector image", mem_mismatches(), 0);
            check(!busy, "R11 back to idle", int'(busy), 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule